// File: doc/BRIEF.md
# Windowed Keyed Watchdog

This block guards a processor against runaway software. A counter advances while the watchdog is enabled. It advances either on every system clock cycle or only on the cycles that carry a pulse from a slow low-power time base. If the counter reaches the selected limit before software services it, the block raises a one-cycle reset request toward the chip reset sequencer. It also sets a sticky flag that records that the watchdog caused the reset.

Software services the watchdog with two byte writes to one service address: first 0x55, then 0xAA. Any other byte written there is treated as a sign of lost control and requests a reset at once. With the bus clock as the time base, an optional window mode accepts service writes only in the last quarter of the period. A write before the window opens also requests a reset at once. Address decoding, the slow time base and the configuration register that drives the select inputs all live outside this block.

Top module: `keyed_wdog`

## Requirements
- R1: Writing 0x55 and then 0xAA to the service port restarts the count, so the next timeout request comes a full period after the 0xAA write.
- R2: Repeated 0x55 writes leave the sequence armed. A 0xAA that has no armed 0x55 before it does not restart the count, and neither does 0xAA followed by 0x55.
- R3: A service write with a byte other than 0x55 or 0xAA raises `rst_req` in the cycle after the write.
- R4: `tmo_sel` = 00 disables the watchdog for both time bases. The count is held at zero, no request is raised, and service writes, including bad bytes, have no effect. Re-enabling starts a full period from zero.
- R5: With `src_bus` = 0, only cycles with `slow_tick` high advance the count. Selects 01, 10 and 11 time out after 32, 256 and 1024 ticks.
- R6: With `src_bus` = 1, every cycle advances the count. Selects 01, 10 and 11 time out after 8192, 65536 and 262144 cycles.
- R7: With `src_bus` = 1 and `win_en` = 1, a service write (either key) made while the count is below three quarters of the period requests a reset at once. The window opens at a count of 6144, 49152 or 196608. Writes at or above that count are accepted.
- R8: With `src_bus` = 0, `win_en` has no effect, and servicing right after a restart is accepted.
- R9: `rst_req` is high for exactly one cycle per event. The request clears the count and the armed key state. Writes in the cycle of the pulse are ignored.
- R10: `cause_flag` is set by every reset request and stays set until `rst`.
- R11: While `rst` is high, the count, the armed state, `rst_req` and `cause_flag` are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-cycle pulse from the slow low-power time base |
| tmo_sel | input | 2 | Timeout select; 00 disables the watchdog |
| src_bus | input | 1 | Time base: 1 selects the bus clock, 0 selects the slow tick |
| win_en | input | 1 | Window mode enable; used only when `src_bus` = 1 |
| svc_wr | input | 1 | Write strobe for the service address |
| svc_data | input | 8 | Byte written to the service address |
| rst_req | output | 1 | One-cycle reset request |
| cause_flag | output | 1 | Sticky flag: a watchdog request has occurred |

## Verification
The following properties are checked on every cycle:
- a bad byte is followed by a request;
- an early write in window mode is followed by a request;
- a disabled watchdog stays silent;
- a request never lasts two cycles;
- the cause flag holds until reset.

Only the bench scenarios can show the exact timeout length for each select and time base, the key-order rules (stray 0xAA, reversed order, repeated 0x55), the window boundary at 6144, and the clearing of the armed state by a request. Each of these is measured as an edge count from a known restart point.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_ARM,
        KIND_FIRE,
        KIND_STRAY,
        KIND_BAD
    } key_kind_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/keyed_wdog_limit.sv
module keyed_wdog_limit
    import keyed_wdog_pkg::*;
#(
    parameter int CW      = 18,
    parameter int SLOW_E1 = 5,
    parameter int SLOW_E2 = 8,
    parameter int SLOW_E3 = 10,
    parameter int BUS_E1  = 13,
    parameter int BUS_E2  = 16,
    parameter int BUS_E3  = 18
) (
    input  logic [1:0]    tmo_sel,
    input  logic          src_bus,
    output logic          enabled,
    output logic [CW-1:0] last_cnt,
    output logic [CW-1:0] win_lo
);
    logic [5:0]  exp_sel;
    logic [63:0] period;

    always_comb begin
        unique case ({src_bus, tmo_sel})
            3'b001:  exp_sel = 6'(SLOW_E1);
            3'b010:  exp_sel = 6'(SLOW_E2);
            3'b011:  exp_sel = 6'(SLOW_E3);
            3'b101:  exp_sel = 6'(BUS_E1);
            3'b110:  exp_sel = 6'(BUS_E2);
            3'b111:  exp_sel = 6'(BUS_E3);
            default: exp_sel = 6'(SLOW_E3);
        endcase
        period   = 64'd1 << exp_sel;
        // last count before expiry, and start of the final quarter
        last_cnt = CW'(period - 64'd1);
        win_lo   = CW'(period - (period >> 2));
        enabled  = |tmo_sel;
    end

endmodule

// File: rtl/keyed_wdog_key.sv
module keyed_wdog_key
    import keyed_wdog_pkg::*;
#(
    parameter logic [7:0] KEY_ARM  = 8'h55,
    parameter logic [7:0] KEY_FIRE = 8'hAA
) (
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       armed,
    output key_kind_e  kind
);
    always_comb begin
        if (!svc_wr) begin
            kind = KIND_NONE;
        end else if (svc_data == KEY_ARM) begin
            kind = KIND_ARM;
        end else if (svc_data == KEY_FIRE) begin
            kind = armed ? KIND_FIRE : KIND_STRAY;
        end else begin
            kind = KIND_BAD;
        end
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int         SLOW_E1  = 5,
    parameter int         SLOW_E2  = 8,
    parameter int         SLOW_E3  = 10,
    parameter int         BUS_E1   = 13,
    parameter int         BUS_E2   = 16,
    parameter int         BUS_E3   = 18,
    parameter logic [7:0] KEY_ARM  = 8'h55,
    parameter logic [7:0] KEY_FIRE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_tick,
    input  logic [1:0] tmo_sel,
    input  logic       src_bus,
    input  logic       win_en,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       rst_req,
    output logic       cause_flag
);
    localparam int CW = max_of(max_of(max_of(SLOW_E1, SLOW_E2), max_of(SLOW_E3, BUS_E1)),
                               max_of(BUS_E2, BUS_E3));

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          req;
        logic          cause;
    } wd_state_t;

    wd_state_t     st_q, st_d;
    logic          enabled;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] win_lo;
    key_kind_e     kind;
    key_kind_e     kind_eff;
    logic          inc;
    logic          early;
    logic          fault;
    logic          expire;

    keyed_wdog_limit #(
        .CW(CW), .SLOW_E1(SLOW_E1), .SLOW_E2(SLOW_E2), .SLOW_E3(SLOW_E3),
        .BUS_E1(BUS_E1), .BUS_E2(BUS_E2), .BUS_E3(BUS_E3)
    ) limit_i (
        .tmo_sel (tmo_sel),
        .src_bus (src_bus),
        .enabled (enabled),
        .last_cnt(last_cnt),
        .win_lo  (win_lo)
    );

    keyed_wdog_key #(
        .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
    ) key_i (
        .svc_wr  (svc_wr),
        .svc_data(svc_data),
        .armed   (st_q.armed),
        .kind    (kind)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        // writes landing in the pulse cycle are dropped
        kind_eff = st_q.req ? KIND_NONE : kind;
        inc      = src_bus | slow_tick;
        early    = src_bus && win_en && (st_q.cnt < win_lo);
        fault    = (kind_eff == KIND_BAD) || ((kind_eff != KIND_NONE) && early);
        expire   = inc && (st_q.cnt >= last_cnt);

        if (!enabled) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (fault || expire) begin
            st_d.req   = 1'b1;
            st_d.cause = 1'b1;
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(inc);
            unique case (kind_eff)
                KIND_ARM:  st_d.armed = 1'b1;
                KIND_FIRE: begin
                    st_d.cnt   = '0;
                    st_d.armed = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req    = st_q.req;
    assign cause_flag = st_q.cause;

    assert_bad_key_R3: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && (svc_data != KEY_ARM) && (svc_data != KEY_FIRE)
         && (tmo_sel != 2'b00) && !rst_req) |=> rst_req);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (tmo_sel == 2'b00) |=> !rst_req);

    assert_early_write_R7: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && src_bus && win_en && (tmo_sel != 2'b00) && !rst_req
         && (st_q.cnt < win_lo)) |=> rst_req);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        cause_flag |=> cause_flag);

    assert_req_marks_cause_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> cause_flag);

    assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rst_req && !cause_flag));

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 195000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_tick = 1'b0;
    logic [1:0] tmo_sel = 2'b11;
    logic       src_bus = 1'b0;
    logic       win_en = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       rst_req;
    logic       cause_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdog dut_i (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .tmo_sel(tmo_sel),
        .src_bus(src_bus), .win_en(win_en), .svc_wr(svc_wr), .svc_data(svc_data),
        .rst_req(rst_req), .cause_flag(cause_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel, input logic bus, input logic win);
        @(negedge clk);
        tmo_sel = sel; src_bus = bus; win_en = win;
        rst = 1'b1; svc_wr = 1'b0; slow_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        svc_wr = 1'b1; svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic idle(input int n, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
    endtask

    // n bus edges from now; request expected after exactly the n-th
    task automatic wait_expire(input int n, input string tag);
        int early_cnt = 0;
        int seen = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k < n && rst_req) early_cnt++;
            if (k == n) seen = int'(rst_req);
        end
        chk({tag, " no early request"}, early_cnt, 0);
        chk({tag, " request at period end"}, seen, 1);
        @(negedge clk);
        chk({tag, " R9 pulse one cycle"}, int'(rst_req), 0);
    endtask

    // n slow ticks, one idle cycle between ticks
    task automatic slow_expire(input int n, input string tag);
        int early_cnt = 0;
        int seen = 0;
        for (int k = 1; k <= n; k++) begin
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
            if (k < n && rst_req) early_cnt++;
            if (k == n) seen = int'(rst_req);
            @(negedge clk);
            if (k < n && rst_req) early_cnt++;
        end
        chk({tag, " no early request"}, early_cnt, 0);
        chk({tag, " request at tick count"}, seen, 1);
    endtask

    task automatic t_reset_state;
        do_reset(2'b11, 1'b0, 1'b0);
        chk("R11 rst_req after reset", int'(rst_req), 0);
        chk("R11 cause_flag after reset", int'(cause_flag), 0);
    endtask

    task automatic t_bus_periods;
        do_reset(2'b01, 1'b1, 1'b0);
        wr(8'h55); wr(8'hAA);
        wait_expire(8192, "R6 R1 bus sel01");
        chk("R10 cause set after timeout", int'(cause_flag), 1);
        do_reset(2'b10, 1'b1, 1'b0);
        wr(8'h55); wr(8'hAA);
        wait_expire(65536, "R6 bus sel10");
    endtask

    task automatic t_slow_periods;
        do_reset(2'b11, 1'b0, 1'b0);
        wr(8'h55); wr(8'hAA);
        slow_expire(1024, "R5 slow sel11");
        do_reset(2'b01, 1'b0, 1'b0);
        wr(8'h55); wr(8'hAA);
        slow_expire(32, "R5 slow sel01");
        do_reset(2'b10, 1'b0, 1'b0);
        wr(8'h55); wr(8'hAA);
        slow_expire(256, "R5 slow sel10");
    endtask

    task automatic t_bad_key;
        int p;
        do_reset(2'b01, 1'b1, 1'b0);
        idle(100, p);
        wr(8'h55);
        wr(8'h12);
        chk("R3 bad byte requests reset", int'(rst_req), 1);
        idle(1, p);
        chk("R9 single pulse after bad byte", p, 0);
        wr(8'hAA);   // armed state was cleared by the request: stray
        wait_expire(8190, "R9 count and key cleared by request");
        idle(10, p);
        chk("R10 cause still set", int'(cause_flag), 1);
        do_reset(2'b01, 1'b1, 1'b0);
        chk("R10 R11 cause cleared by rst", int'(cause_flag), 0);
    endtask

    task automatic t_key_order;
        int p;
        do_reset(2'b01, 1'b1, 1'b0);
        idle(5000, p);
        chk("R2 quiet before service", p, 0);
        wr(8'h55); wr(8'h55); wr(8'hAA);
        wait_expire(8192, "R2 R1 repeated arm then fire");
        do_reset(2'b01, 1'b1, 1'b0);
        idle(100, p);
        wr(8'hAA);
        wr(8'h55);
        wait_expire(8090, "R2 reversed order no restart");
    endtask

    task automatic t_window;
        int p;
        do_reset(2'b01, 1'b1, 1'b1);
        idle(6143, p);
        wr(8'h55);
        chk("R7 key at count 6143 is early", int'(rst_req), 1);
        do_reset(2'b01, 1'b1, 1'b1);
        idle(6144, p);
        wr(8'h55);
        chk("R7 key at count 6144 accepted", int'(rst_req), 0);
        wr(8'hAA);
        chk("R7 fire inside window accepted", int'(rst_req), 0);
        wr(8'h55);
        chk("R7 early write after restart", int'(rst_req), 1);
    endtask

    task automatic t_window_slow;
        do_reset(2'b01, 1'b0, 1'b1);
        wr(8'h55);
        chk("R8 arm at count 0 accepted", int'(rst_req), 0);
        wr(8'hAA);
        chk("R8 fire at count 0 accepted", int'(rst_req), 0);
        slow_expire(32, "R8 slow window ignored");
    endtask

    task automatic t_disabled;
        int p;
        do_reset(2'b00, 1'b1, 1'b0);
        idle(20000, p);
        chk("R4 no request while disabled", p, 0);
        wr(8'h12);
        chk("R4 bad byte ignored while disabled", int'(rst_req), 0);
        chk("R4 cause untouched while disabled", int'(cause_flag), 0);
        tmo_sel = 2'b01;
        wait_expire(8192, "R4 full period after enable");
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_bus_periods();
        t_slow_periods();
        t_bad_key();
        t_key_order();
        t_window();
        t_window_slow();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule